// File: doc/BRIEF.md
# Ping-pong Ethernet receive buffer

This block takes received Ethernet frames from the MAC as a byte stream and stores each one in one of two equal receive buffers. The CPU reads one buffer at a time through a read window, and a single byte-wide status/control register tells it which buffer received the newest frame. The same register lets the CPU pick the buffer shown in the window and clears the receive interrupt. The receiver only ever fills the buffer that the CPU is not looking at. The CPU can therefore read a frame in place, or run code held in it, while the next frame streams into the other half.

Each stored frame begins with a two-byte length word, followed by the frame bytes from the destination address onward. With a 14-byte Ethernet header, the IP header therefore starts at window offset 16. A frame is kept only if it fits and its last byte is flagged with a good CRC. A frame is also dropped if the receiver is off, or if the buffer it would land in still holds a frame the CPU has not yet looked at. The CPU acknowledges a frame by switching its view to the buffer that frame landed in.

Top module: `eth_rx_pingpong`

## Requirements
- R1: After reset the register reads 0x00 and `irq` is low.
- R2: A register write copies data bit 0 into the receiver enable and data bit 1 into the view select. Both read back at the same positions. Register bits 3, 4, 6 and 7 always read 0, and writes to bits 2 to 7 have no effect on any state.
- R3: Window reads return, one cycle after the address is presented, the byte at that offset in the buffer chosen by the view select at the time of the read.
- R4: A frame is written into the buffer whose number is the inverse of the view select at its first byte. If the view select is switched to that buffer before the frame's last byte, the frame is discarded.
- R5: Frame byte k is stored at offset 2+k. Offset 0 holds the low byte and offset 1 the high byte of the stored frame's byte count, so the IP header of an Ethernet frame sits at offset 16.
- R6: When a frame is accepted, register bit 5 and `irq` rise in the following cycle, and bit 2 then reads the number of the buffer the frame landed in.
- R7: Register bit 5 falls one cycle after the view select equals bit 2 (the landing buffer).
- R8: Any register write lowers `irq`, unless a frame is accepted in the same cycle, in which case `irq` stays high.
- R9: A frame whose last byte has `rx_crc_ok` low sets neither bit 5 nor `irq`, and leaves the length word of its buffer unchanged.
- R10: A frame of more than 2046 bytes is discarded. A frame of exactly 2046 bytes is accepted.
- R11: A frame that starts while bit 5 is set, or while the receiver is disabled, is dropped, and the earlier frame's length word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A received frame byte is present on `rx_data` |
| rx_data | input | 8 | Received frame byte |
| rx_last | input | 1 | This byte is the last one of the frame |
| rx_crc_ok | input | 1 | CRC verdict, sampled with the last byte |
| reg_wr | input | 1 | Write strobe for the status/control register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value: bit 0 enable, bit 1 view, bit 2 landing buffer, bit 5 frame waiting |
| win_addr | input | 11 | Byte offset in the read window |
| win_rdata | output | 8 | Window byte, one cycle after the address |
| irq | output | 1 | Receive interrupt |

## Verification
The assertions take for granted that `rx_last` and `rx_crc_ok` mean something only on beats where `rx_valid` is high, and that the MAC never starts a new frame before it has ended the current one. The assertions also take for granted that register writes can land in any cycle, including in the middle of a frame and on its final beat. The stimulus sends each frame as a run of valid beats with `rx_last` on the final one only, and holds the CRC flag at a fixed value for the whole frame. It places register writes on the first, middle and last beats of frames, so that the abort case and the case where a write and an acceptance fall in the same cycle are both covered.

// File: rtl/eth_rxpp_pkg.sv
// Shared definitions for the ping-pong receive buffer.
// Assumes: one byte-wide status/control register whose bit positions are
// fixed because software decodes them.
package eth_rxpp_pkg;

    // Register bit positions (software-visible, must not move)
    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_VIEW_BIT = 1;
    localparam int CTL_LAND_BIT = 2;
    localparam int CTL_PEND_BIT = 5;

    // Bytes of length word placed ahead of each stored frame
    localparam int HDR_BYTES = 2;

    // Architectural state held by the register block
    typedef struct packed {
        logic en;
        logic view;
        logic landing;
        logic pending;
    } ctl_state_t;

    // Build the register read value from the state fields
    function automatic logic [7:0] pack_status(input ctl_state_t s);
        logic [7:0] v;
        v               = 8'h00;
        v[CTL_EN_BIT]   = s.en;
        v[CTL_VIEW_BIT] = s.view;
        v[CTL_LAND_BIT] = s.landing;
        v[CTL_PEND_BIT] = s.pending;
        return v;
    endfunction

endpackage

// File: rtl/eth_rxpp_ram.sv
// One receive buffer: a byte-wide simple dual-port RAM.
// Write port from the frame writer, registered read port for the CPU window.
// Assumes: no read/write collision matters, because the writer never targets
// the buffer being viewed. Contents are not reset.
module eth_rxpp_ram #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    // Store one byte per cycle when enabled
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read, one cycle latency
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/eth_rxpp_writer.sv
// Frame writer: steers received bytes into the non-viewed buffer, after the
// two-byte length slot, and decides at the last byte whether to accept the
// frame.
// Assumes: rx_last and rx_crc_ok are only meaningful with rx_valid. Frames do
// not overlap. The target buffer is latched at the first byte. A frame is
// discarded if the receiver is off or a frame is still pending at its start,
// if it grows past the buffer, or if the CPU switches view onto the target.
module eth_rxpp_writer
    import eth_rxpp_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    localparam int AW       = $clog2(BUF_BYTES),
    localparam int LW       = AW + 1,
    localparam int MAX_FRM  = BUF_BYTES - HDR_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic          rx_crc_ok,
    input  logic          en,
    input  logic          view,
    input  logic          pending,
    output logic          wr_en,
    output logic          wr_buf,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          commit,
    output logic          commit_buf,
    output logic [LW-1:0] commit_len
);

    logic          in_frame_q;
    logic          disc_q;
    logic          tgt_q;
    logic [LW-1:0] cnt_q;

    logic          first_beat;
    logic          cur_tgt;
    logic          cur_disc;
    logic [LW-1:0] cur_cnt;
    logic          bad;

    // Resolve target, discard state and byte index for the current beat
    always_comb begin
        first_beat = !in_frame_q;
        cur_tgt    = first_beat ? ~view : tgt_q;
        cur_disc   = first_beat ? (!en || pending) : disc_q;
        cur_cnt    = first_beat ? '0 : cnt_q;
        bad        = cur_disc || (view == cur_tgt) || (cur_cnt >= LW'(MAX_FRM));
    end

    // Drive the RAM write port and the accept pulse
    always_comb begin
        wr_en      = rx_valid && !bad;
        wr_buf     = cur_tgt;
        wr_addr    = AW'(cur_cnt + LW'(HDR_BYTES));
        wr_data    = rx_data;
        commit     = rx_valid && rx_last && rx_crc_ok && !bad;
        commit_buf = cur_tgt;
        commit_len = cur_cnt + LW'(1);
    end

    // Track frame progress between beats
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            disc_q     <= 1'b0;
            tgt_q      <= 1'b0;
            cnt_q      <= '0;
        end else if (rx_valid) begin
            if (rx_last) begin
                in_frame_q <= 1'b0;
            end else begin
                in_frame_q <= 1'b1;
                tgt_q      <= cur_tgt;
                disc_q     <= bad;
                if (!bad) begin
                    cnt_q <= cur_cnt + LW'(1);
                end
            end
        end
    end

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (commit_len <= LW'(MAX_FRM)));  // R10

    AST_NO_ACCEPT_OVER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !pending);  // R11

endmodule

// File: rtl/eth_rxpp_ctrl.sv
// Status/control register, frame-waiting flag, interrupt, and the per-buffer
// length words.
// Assumes: the writer gives at most one accept pulse per cycle. An accept
// takes priority over a register write for the interrupt. The waiting flag
// drops once the viewed buffer is the landing buffer.
module eth_rxpp_ctrl
    import eth_rxpp_pkg::*;
#(
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    input  logic          commit,
    input  logic          commit_buf,
    input  logic [LW-1:0] commit_len,
    output ctl_state_t    st,
    output logic          irq,
    output logic [7:0]    reg_rdata,
    output logic [LW-1:0] view_len
);

    localparam int NBUF = 2;

    logic [LW-1:0] hdr_q [NBUF];
    logic          unused_wdata;

    assign unused_wdata = ^reg_wdata[7:2];

    // Enable and view select follow register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.en   <= 1'b0;
            st.view <= 1'b0;
        end else if (reg_wr) begin
            st.en   <= reg_wdata[CTL_EN_BIT];
            st.view <= reg_wdata[CTL_VIEW_BIT];
        end
    end

    // Landing buffer and frame-waiting flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.landing <= 1'b0;
            st.pending <= 1'b0;
        end else if (commit) begin
            st.landing <= commit_buf;
            st.pending <= 1'b1;
        end else if (st.view == st.landing) begin
            st.pending <= 1'b0;
        end
    end

    // Interrupt: set by accept, cleared by any register write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (commit) begin
            irq <= 1'b1;
        end else if (reg_wr) begin
            irq <= 1'b0;
        end
    end

    // One length word per buffer, loaded on accept into that buffer
    for (genvar b = 0; b < NBUF; b++) begin : g_hdr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hdr_q[b] <= '0;
            end else if (commit && (commit_buf == 1'(b))) begin
                hdr_q[b] <= commit_len;
            end
        end
    end

    // Register read value and length word of the viewed buffer
    always_comb begin
        reg_rdata = pack_status(st);
        view_len  = hdr_q[st.view];
    end

    AST_FLAG_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (st.pending && irq && (st.landing == $past(commit_buf))));  // R6

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (st.pending && (st.view == st.landing) && !commit) |=> !st.pending);  // R7

    AST_IRQ_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !commit) |=> !irq);  // R8

endmodule

// File: rtl/eth_rx_pingpong.sv
// Top level of the ping-pong receive buffer: two buffer RAMs, the frame
// writer, the register block, and the CPU window read path.
// Assumes: the window read path has one cycle of latency, and offsets 0 and 1
// return the length word of the viewed buffer instead of RAM bytes.
module eth_rx_pingpong
    import eth_rxpp_pkg::*;
#(
    parameter int BUF_BYTES = 2048
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_valid,
    input  logic [7:0]                   rx_data,
    input  logic                         rx_last,
    input  logic                         rx_crc_ok,
    input  logic                         reg_wr,
    input  logic [7:0]                   reg_wdata,
    output logic [7:0]                   reg_rdata,
    input  logic [$clog2(BUF_BYTES)-1:0] win_addr,
    output logic [7:0]                   win_rdata,
    output logic                         irq
);

    localparam int AW   = $clog2(BUF_BYTES);
    localparam int LW   = AW + 1;
    localparam int NBUF = 2;

    ctl_state_t    st;
    logic          wr_en;
    logic          wr_buf;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          commit;
    logic          commit_buf;
    logic [LW-1:0] commit_len;
    logic [LW-1:0] view_len;
    logic [15:0]   view_len16;
    logic [7:0]    ram_q [NBUF];
    logic          view_q;
    logic          hdr_sel_q;
    logic [7:0]    hdr_byte_q;

    eth_rxpp_writer #(.BUF_BYTES(BUF_BYTES)) u_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_last    (rx_last),
        .rx_crc_ok  (rx_crc_ok),
        .en         (st.en),
        .view       (st.view),
        .pending    (st.pending),
        .wr_en      (wr_en),
        .wr_buf     (wr_buf),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .commit     (commit),
        .commit_buf (commit_buf),
        .commit_len (commit_len)
    );

    eth_rxpp_ctrl #(.LW(LW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .commit     (commit),
        .commit_buf (commit_buf),
        .commit_len (commit_len),
        .st         (st),
        .irq        (irq),
        .reg_rdata  (reg_rdata),
        .view_len   (view_len)
    );

    // Two identical buffers, each written only when the writer targets it
    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        eth_rxpp_ram #(.DEPTH(BUF_BYTES)) u_ram (
            .clk   (clk),
            .we    (wr_en && (wr_buf == 1'(b))),
            .waddr (wr_addr),
            .wdata (wr_data),
            .raddr (win_addr),
            .rdata (ram_q[b])
        );
    end

    assign view_len16 = 16'(view_len);

    // Capture view and length-word byte alongside the RAM read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            view_q     <= 1'b0;
            hdr_sel_q  <= 1'b0;
            hdr_byte_q <= 8'h00;
        end else begin
            view_q     <= st.view;
            hdr_sel_q  <= (win_addr < AW'(HDR_BYTES));
            hdr_byte_q <= win_addr[0] ? view_len16[15:8] : view_len16[7:0];
        end
    end

    // Window output: length word or RAM byte of the viewed buffer
    always_comb begin
        win_rdata = hdr_sel_q ? hdr_byte_q : ram_q[view_q];
    end

    AST_NO_WRITE_VIEWED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_buf != st.view));  // R4

endmodule

// File: tb/tb_eth_rx_pingpong.sv
module tb_eth_rx_pingpong;

    localparam int BUF  = 2048;
    localparam int AW   = $clog2(BUF);
    localparam int MAXF = BUF - 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = 8'h00;
    logic          rx_last = 1'b0;
    logic          rx_crc_ok = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = 8'h00;
    logic [7:0]    reg_rdata;
    logic [AW-1:0] win_addr = '0;
    logic [7:0]    win_rdata;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    always #5 clk = ~clk;

    eth_rx_pingpong #(.BUF_BYTES(BUF)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_crc_ok(rx_crc_ok), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_addr(win_addr),
        .win_rdata(win_rdata), .irq(irq)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'(seed * 31 + k * 7 + (k >> 8));
    endfunction

    // ---------------- reference model (behavioural) ----------------
    logic [7:0] m_mem [2][BUF];
    int  m_hdr [2];
    bit  m_en, m_view, m_land, m_pend, m_irq, m_inf, m_disc, m_tgt;
    int  m_cnt;
    logic [7:0] m_rd;

    initial begin
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < BUF; i++) m_mem[b][i] = 8'hxx;
        end
    end

    always @(posedge clk) begin : mdl
        bit o_view, o_land, o_pend, first, ctgt, cdisc, bad, acc;
        int ccnt;
        if (!rst_n) begin
            m_en = 0; m_view = 0; m_land = 0; m_pend = 0; m_irq = 0;
            m_inf = 0; m_disc = 0; m_tgt = 0; m_cnt = 0;
            m_hdr[0] = 0; m_hdr[1] = 0; m_rd = 8'hxx;
        end else begin
            o_view = m_view; o_land = m_land; o_pend = m_pend;
            if (int'(win_addr) == 0)      m_rd = 8'(m_hdr[o_view]);
            else if (int'(win_addr) == 1) m_rd = 8'(m_hdr[o_view] >> 8);
            else                          m_rd = m_mem[o_view][win_addr];
            acc = 0;
            if (rx_valid) begin
                first = !m_inf;
                ctgt  = first ? !o_view : m_tgt;
                cdisc = first ? (!m_en || o_pend) : m_disc;
                ccnt  = first ? 0 : m_cnt;
                bad   = cdisc || (o_view == ctgt) || (ccnt >= MAXF);
                if (!bad) m_mem[ctgt][ccnt + 2] = rx_data;
                if (rx_last) begin
                    m_inf = 0;
                    if (!bad && rx_crc_ok) begin
                        acc = 1; m_hdr[ctgt] = ccnt + 1; m_land = ctgt;
                    end
                end else begin
                    m_inf = 1; m_tgt = ctgt; m_disc = bad;
                    if (!bad) m_cnt = ccnt + 1;
                end
            end
            if (acc) m_pend = 1; else if (o_view == o_land) m_pend = 0;
            if (acc) m_irq = 1; else if (reg_wr) m_irq = 0;
            if (reg_wr) begin m_en = reg_wdata[0]; m_view = reg_wdata[1]; end
        end
    end

    // Per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (live && rst_n && !done) begin
            check("R2", "enable/view bits", int'(reg_rdata[1:0]), int'({m_view, m_en}));
            check("R6", "landing bit", int'(reg_rdata[2]), int'(m_land));
            check("R7", "waiting bit", int'(reg_rdata[5]), int'(m_pend));
            check("R2", "reserved bits", int'({reg_rdata[7:6], reg_rdata[4:3]}), 0);
            check("R8", "irq", int'(irq), int'(m_irq));
            if (!$isunknown(m_rd)) check("R3", "window byte", int'(win_rdata), int'(m_rd));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk); win_addr = AW'(a);
        @(negedge clk); v = int'(win_rdata);
    endtask

    task automatic send(input int n, input int seed, input bit ok,
                        input int sw_at, input logic [7:0] sw_val);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rx_valid  = 1'b1;
            rx_data   = pat(seed, k);
            rx_last   = (k == n - 1);
            rx_crc_ok = ok;
            reg_wr    = (k == sw_at);
            reg_wdata = sw_val;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_crc_ok = 1'b0; reg_wr = 1'b0;
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        live  = 1'b1;
        @(negedge clk);
        check("R1", "register after reset", int'(reg_rdata), 0);
        check("R1", "irq after reset", int'(irq), 0);

        // Enable, view 0: frame lands in buffer 1
        wr(8'h01);
        check("R2", "readback 0x01", int'(reg_rdata), 1);
        send(60, 5, 1'b1, -1, 8'h00);
        idle(1);
        check("R6", "accept flags", int'(reg_rdata), 8'h25);
        check("R6", "irq on accept", int'(irq), 1);
        // View buffer 1 with reserved bits set
        wr(8'hFF);
        check("R8", "irq after write", int'(irq), 0);
        idle(1);
        check("R7", "waiting cleared", int'(reg_rdata), 8'h07);
        rd(0, v);  check("R5", "length low", v, 60);
        rd(1, v);  check("R5", "length high", v, 0);
        rd(16, v); check("R5", "IP header byte", v, int'(pat(5, 14)));
        rd(2, v);  check("R3", "first byte", v, int'(pat(5, 0)));
        rd(61, v); check("R3", "last byte", v, int'(pat(5, 59)));

        // View 1: frame lands in buffer 0, then a second is dropped
        send(100, 9, 1'b1, -1, 8'h00);
        idle(1);
        check("R4", "landing in buffer 0", int'(reg_rdata[2]), 0);
        wr(8'h03);
        send(80, 11, 1'b1, -1, 8'h00);
        idle(1);
        check("R11", "dropped while waiting: irq", int'(irq), 0);
        check("R11", "dropped while waiting: reg", int'(reg_rdata), 8'h23);
        wr(8'h01);
        rd(0, v); check("R11", "earlier length kept", v, 100);
        rd(2, v); check("R11", "earlier data kept", v, int'(pat(9, 0)));

        // Bad CRC into buffer 1
        send(50, 13, 1'b0, -1, 8'h00);
        idle(1);
        check("R9", "bad crc irq", int'(irq), 0);
        check("R9", "bad crc waiting", int'(reg_rdata[5]), 0);
        wr(8'h03);
        rd(0, v); check("R9", "length unchanged", v, 60);

        // Oversize then exact-limit frame into buffer 0
        send(2050, 17, 1'b1, -1, 8'h00);
        idle(1);
        check("R10", "oversize irq", int'(irq), 0);
        send(MAXF, 19, 1'b1, -1, 8'h00);
        idle(1);
        check("R10", "limit frame accepted", int'(irq), 1);
        wr(8'h01);
        rd(0, v);    check("R10", "limit length low", v, MAXF & 8'hFF);
        rd(1, v);    check("R10", "limit length high", v, MAXF >> 8);
        rd(BUF - 1, v); check("R10", "limit last byte", v, int'(pat(19, MAXF - 1)));

        // Receiver disabled
        wr(8'h00);
        send(40, 21, 1'b1, -1, 8'h00);
        idle(1);
        check("R11", "disabled: no irq", int'(irq), 0);
        check("R11", "disabled: no waiting", int'(reg_rdata[5]), 0);

        // View switched onto target mid-frame: abort
        wr(8'h01);
        send(70, 23, 1'b1, 30, 8'h03);
        idle(1);
        check("R4", "abort: no irq", int'(irq), 0);
        check("R4", "abort: register", int'(reg_rdata), 8'h03);
        rd(0, v); check("R4", "abort: length kept", v, 60);

        // Write on the final beat: accept wins for irq
        send(64, 25, 1'b1, 63, 8'h01);
        check("R8", "accept beats write", int'(irq), 1);
        idle(1);
        check("R7", "waiting cleared after view", int'(reg_rdata[5]), 0);
        rd(0, v); check("R5", "length of last frame", v, 64);

        idle(3);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule